// File: doc/BRIEF.md
# Target Address-Range Traffic Monitor

This block watches requests that the on-chip fabric sends toward PCIe BAR windows and CXL host-managed memory. Each presented request carries a 48-bit target address, the index of the destination root port, a flag marking it as CXL rather than BAR traffic, a read/write flag and a byte count. A filter decides whether the request is counted. A bank of counters then accumulates read requests, write requests, read bytes, write bytes and elapsed fabric cycles.

The filter has two modes. With the address filter off, only BAR traffic is eligible, and a per-port mask selects which of eight root ports count. With the address filter on, a masked comparison against a base address selects traffic of either kind. Configuration is loaded through a single write strobe, and only while counting is paused. Out of reset the block counts BAR traffic to every root port.

Top module: `tgt_traffic_mon`

## Requirements
- R1: Synchronous reset clears all five counters and loads the default filter: port mask 8'hFF, address filter off, base and mask zero. After reset a BAR request to root port 7 is counted.
- R2: The cycle counter rises by exactly one at each clock edge where `count_en` is high and holds while `count_en` is low.
- R3: No request counter or byte counter changes unless `req_valid` and `count_en` are both high at the clock edge.
- R4: An accepted read (`req_is_wr`=0) adds one to the read-request counter and `req_bytes` to the read-byte counter. An accepted write does the same to the write counters. Results are visible after the edge that samples the request.
- R5: With the address filter off, a BAR request (`req_is_cxl`=0) is accepted only when bit `req_rp` of the port mask is 1.
- R6: With the address filter off, a CXL request (`req_is_cxl`=1) is never accepted, whatever its port or address.
- R7: With the address filter on, a request of either kind is accepted exactly when (`req_addr` AND mask) equals (base AND mask). The port mask is not consulted in this mode.
- R8: A `cfg_wr` pulse while `count_en` is low loads all four filter fields at that edge. A `cfg_wr` pulse while `count_en` is high leaves the filter unchanged.
- R9: With base 48'h10000 and mask 48'hFFF00, addresses 48'h10000 through 48'h100FF are accepted. 48'h0FFFF and 48'h10100 are rejected. Address bits outside the mask are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Counting enabled; configuration writes accepted only while low |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_rp_mask | input | 8 | Root-port select mask, bit n for port n |
| cfg_addr_base | input | 48 | Address-window base |
| cfg_addr_mask | input | 48 | Address-window compare mask |
| cfg_addr_en | input | 1 | Select address-window filtering |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 48 | Request target address |
| req_rp | input | 3 | Destination root-port index |
| req_is_cxl | input | 1 | 1 = CXL memory traffic, 0 = BAR traffic |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_bytes | input | 8 | Bytes carried by the request |
| cnt_rd_req | output | CNT_W | Accepted read requests |
| cnt_wr_req | output | CNT_W | Accepted write requests |
| cnt_rd_bytes | output | CNT_W | Bytes of accepted reads |
| cnt_wr_bytes | output | CNT_W | Bytes of accepted writes |
| cnt_cycles | output | CNT_W | Cycles with counting enabled |

## Verification
The assertions assume that reset is held for at least one clock edge before any check is meaningful. They also assume that counters do not wrap within one step, which holds because a single request adds at most 255 bytes and runs stay far below 2^32. The stimulus follows these assumptions: it asserts reset from time zero and keeps totals small. It changes configuration only through the strobe, and drives every input only on the falling edge, so each request occupies exactly one sampling edge.

// File: rtl/tgt_mon_pkg.sv
package tgt_mon_pkg;

    parameter int ADDR_W = 48;
    parameter int NUM_RP = 8;
    parameter int RP_W   = $clog2(NUM_RP);
    parameter int BYTE_W = 8;

    // counter slots in the bank
    parameter int NUM_EV      = 5;
    parameter int IX_RD_REQ   = 0;
    parameter int IX_WR_REQ   = 1;
    parameter int IX_RD_BYTES = 2;
    parameter int IX_WR_BYTES = 3;
    parameter int IX_CYCLES   = 4;

    typedef enum logic {DIR_READ = 1'b0, DIR_WRITE = 1'b1} req_dir_e;

    typedef struct packed {
        logic [NUM_RP-1:0] rp_mask;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic              addr_en;
    } mon_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [RP_W-1:0]   rp;
        logic              is_cxl;
        req_dir_e          dir;
        logic [BYTE_W-1:0] bytes;
    } mon_req_t;

    localparam mon_cfg_t CFG_DEFAULT = '{
        rp_mask: {NUM_RP{1'b1}},
        base:    '0,
        mask:    '0,
        addr_en: 1'b0
    };

    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input logic [ADDR_W-1:0] mask);
        return ((addr & mask) == (base & mask));
    endfunction

endpackage

// File: rtl/tgt_mon_cfg.sv
module tgt_mon_cfg
    import tgt_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     count_en,
    input  logic     cfg_wr,
    input  mon_cfg_t cfg_in,
    output mon_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_DEFAULT;
        end else if (cfg_wr && !count_en) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/tgt_mon_filter.sv
module tgt_mon_filter
    import tgt_mon_pkg::*;
(
    input  mon_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RP_W-1:0]   rp,
    input  logic              is_cxl,
    output logic              hit
);

    always_comb begin
        if (cfg.addr_en) begin
            hit = in_window(addr, cfg.base, cfg.mask);
        end else begin
            hit = !is_cxl && cfg.rp_mask[rp];
        end
    end

endmodule

// File: rtl/tgt_mon_counters.sv
module tgt_mon_counters #(
    parameter int NUM = 5,
    parameter int W   = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc [NUM],
    output logic [W-1:0] cnt [NUM]
);

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        logic [W-1:0] acc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else begin
                acc_q <= acc_q + inc[g];
            end
        end
        assign cnt[g] = acc_q;
    end

endmodule

// File: rtl/tgt_traffic_mon.sv
module tgt_traffic_mon
    import tgt_mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  logic              cfg_wr,
    input  logic [NUM_RP-1:0] cfg_rp_mask,
    input  logic [ADDR_W-1:0] cfg_addr_base,
    input  logic [ADDR_W-1:0] cfg_addr_mask,
    input  logic              cfg_addr_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [RP_W-1:0]   req_rp,
    input  logic              req_is_cxl,
    input  logic              req_is_wr,
    input  logic [BYTE_W-1:0] req_bytes,
    output logic [CNT_W-1:0]  cnt_rd_req,
    output logic [CNT_W-1:0]  cnt_wr_req,
    output logic [CNT_W-1:0]  cnt_rd_bytes,
    output logic [CNT_W-1:0]  cnt_wr_bytes,
    output logic [CNT_W-1:0]  cnt_cycles
);

    mon_cfg_t     cfg_in;
    mon_cfg_t     cfg_q;
    mon_req_t     req;
    logic         filt_hit;
    logic         take;
    logic         take_rd;
    logic         take_wr;
    logic [CNT_W-1:0] inc [NUM_EV];
    logic [CNT_W-1:0] cnt [NUM_EV];

    assign cfg_in = '{rp_mask: cfg_rp_mask, base: cfg_addr_base,
                      mask: cfg_addr_mask, addr_en: cfg_addr_en};

    assign req = '{valid: req_valid, addr: req_addr, rp: req_rp,
                   is_cxl: req_is_cxl, dir: req_dir_e'(req_is_wr),
                   bytes: req_bytes};

    tgt_mon_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .cfg_wr   (cfg_wr),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q)
    );

    tgt_mon_filter u_filter (
        .cfg    (cfg_q),
        .addr   (req.addr),
        .rp     (req.rp),
        .is_cxl (req.is_cxl),
        .hit    (filt_hit)
    );

    assign take    = req.valid && count_en && filt_hit;
    assign take_rd = take && (req.dir == DIR_READ);
    assign take_wr = take && (req.dir == DIR_WRITE);

    always_comb begin
        inc[IX_RD_REQ]   = take_rd ? CNT_W'(1) : '0;
        inc[IX_WR_REQ]   = take_wr ? CNT_W'(1) : '0;
        inc[IX_RD_BYTES] = take_rd ? CNT_W'(req.bytes) : '0;
        inc[IX_WR_BYTES] = take_wr ? CNT_W'(req.bytes) : '0;
        inc[IX_CYCLES]   = count_en ? CNT_W'(1) : '0;
    end

    tgt_mon_counters #(.NUM(NUM_EV), .W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (inc),
        .cnt (cnt)
    );

    assign cnt_rd_req   = cnt[IX_RD_REQ];
    assign cnt_wr_req   = cnt[IX_WR_REQ];
    assign cnt_rd_bytes = cnt[IX_RD_BYTES];
    assign cnt_wr_bytes = cnt[IX_WR_BYTES];
    assign cnt_cycles   = cnt[IX_CYCLES];

endmodule

// File: rtl/tgt_mon_chk.sv
module tgt_mon_chk
    import tgt_mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             count_en,
    input logic             req_valid,
    input mon_cfg_t         cfg_q,
    input logic [CNT_W-1:0] cnt_rd_req,
    input logic [CNT_W-1:0] cnt_wr_req,
    input logic [CNT_W-1:0] cnt_rd_bytes,
    input logic [CNT_W-1:0] cnt_wr_bytes,
    input logic [CNT_W-1:0] cnt_cycles
);

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        count_en |=> (cnt_cycles == $past(cnt_cycles) + 1'b1)); // R2

    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(cnt_cycles)); // R2

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && count_en) |=> ($stable(cnt_rd_req) && $stable(cnt_wr_req)
                                      && $stable(cnt_rd_bytes) && $stable(cnt_wr_bytes))); // R3

    AST_REQ_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((cnt_rd_req == $past(cnt_rd_req) || cnt_rd_req == $past(cnt_rd_req) + 1'b1)
                    && (cnt_wr_req == $past(cnt_wr_req) || cnt_wr_req == $past(cnt_wr_req) + 1'b1))); // R4

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !(!$stable(cnt_rd_req) && !$stable(cnt_wr_req))); // R4

    AST_RD_BYTES_NEED_REQ: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_rd_bytes) |-> !$stable(cnt_rd_req)); // R4

    AST_WR_BYTES_NEED_REQ: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_wr_bytes) |-> !$stable(cnt_wr_req)); // R4

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        count_en |=> $stable(cfg_q)); // R8

endmodule

bind tgt_traffic_mon tgt_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .count_en     (count_en),
    .req_valid    (req_valid),
    .cfg_q        (cfg_q),
    .cnt_rd_req   (cnt_rd_req),
    .cnt_wr_req   (cnt_wr_req),
    .cnt_rd_bytes (cnt_rd_bytes),
    .cnt_wr_bytes (cnt_wr_bytes),
    .cnt_cycles   (cnt_cycles)
);

// File: tb/tb_tgt_traffic_mon.sv
module tb_tgt_traffic_mon;

    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          count_en = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_rp_mask = '0;
    logic [47:0]   cfg_addr_base = '0;
    logic [47:0]   cfg_addr_mask = '0;
    logic          cfg_addr_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [47:0]   req_addr = '0;
    logic [2:0]    req_rp = '0;
    logic          req_is_cxl = 1'b0;
    logic          req_is_wr = 1'b0;
    logic [7:0]    req_bytes = '0;
    logic [CW-1:0] cnt_rd_req, cnt_wr_req, cnt_rd_bytes, cnt_wr_bytes, cnt_cycles;

    int checks = 0;
    int failures = 0;
    logic [CW-1:0] m_rd_req = '0, m_wr_req = '0, m_rd_bytes = '0, m_wr_bytes = '0;
    logic [CW-1:0] cyc0;

    always #10 clk = ~clk;

    tgt_traffic_mon #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .count_en(count_en), .cfg_wr(cfg_wr),
        .cfg_rp_mask(cfg_rp_mask), .cfg_addr_base(cfg_addr_base),
        .cfg_addr_mask(cfg_addr_mask), .cfg_addr_en(cfg_addr_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_rp(req_rp),
        .req_is_cxl(req_is_cxl), .req_is_wr(req_is_wr), .req_bytes(req_bytes),
        .cnt_rd_req(cnt_rd_req), .cnt_wr_req(cnt_wr_req),
        .cnt_rd_bytes(cnt_rd_bytes), .cnt_wr_bytes(cnt_wr_bytes),
        .cnt_cycles(cnt_cycles)
    );

    // sel 0: port mask 0x05, address filter off; sel 1: window 0x10000/0xFFF00, port mask 0
    typedef struct packed {
        logic        sel;
        logic        cxl;
        logic        wr;
        logic [2:0]  rp;
        logic [7:0]  bytes;
        logic [47:0] addr;
        logic        hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 3'd0, 8'd64,  48'h000000000500, 1'b1}, // R5 port 0 on
        '{1'b0, 1'b0, 1'b1, 3'd2, 8'd32,  48'h000000000600, 1'b1}, // R5 port 2 on
        '{1'b0, 1'b0, 1'b0, 3'd1, 8'd16,  48'h000000000700, 1'b0}, // R5 port 1 off
        '{1'b0, 1'b0, 1'b1, 3'd7, 8'd8,   48'h000000000800, 1'b0}, // R5 port 7 off
        '{1'b0, 1'b1, 1'b0, 3'd0, 8'd4,   48'h000000010000, 1'b0}, // R6 CXL dropped
        '{1'b0, 1'b1, 1'b1, 3'd2, 8'd4,   48'h000000010000, 1'b0}, // R6 CXL dropped
        '{1'b1, 1'b0, 1'b0, 3'd3, 8'd128, 48'h000000010000, 1'b1}, // R7 port mask ignored
        '{1'b1, 1'b1, 1'b1, 3'd0, 8'd4,   48'h0000000100FF, 1'b1}, // R9 top of window
        '{1'b1, 1'b1, 1'b0, 3'd0, 8'd2,   48'h00000000FFFF, 1'b0}, // R9 below window
        '{1'b1, 1'b0, 1'b1, 3'd1, 8'd2,   48'h000000010100, 1'b0}, // R9 above window
        '{1'b1, 1'b1, 1'b0, 3'd6, 8'd255, 48'h0ABC00010080, 1'b1}, // R9 unmasked high bits
        '{1'b1, 1'b0, 1'b1, 3'd5, 8'd1,   48'h000000010042, 1'b1}  // R7 BAR in window
    };

    task automatic check(input bit ok, input string tag,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(cnt_rd_req   == m_rd_req,   {tag, " rd_req"},   cnt_rd_req,   m_rd_req);
        check(cnt_wr_req   == m_wr_req,   {tag, " wr_req"},   cnt_wr_req,   m_wr_req);
        check(cnt_rd_bytes == m_rd_bytes, {tag, " rd_bytes"}, cnt_rd_bytes, m_rd_bytes);
        check(cnt_wr_bytes == m_wr_bytes, {tag, " wr_bytes"}, cnt_wr_bytes, m_wr_bytes);
    endtask

    task automatic send(input logic cxl, input logic wr, input logic [2:0] rp,
                        input logic [7:0] nb, input logic [47:0] a,
                        input logic valid, input logic exp_hit, input string tag);
        @(negedge clk);
        req_valid = valid; req_is_cxl = cxl; req_is_wr = wr;
        req_rp = rp; req_bytes = nb; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            if (wr) begin m_wr_req += 1; m_wr_bytes += CW'(nb); end
            else    begin m_rd_req += 1; m_rd_bytes += CW'(nb); end
        end
        check_all(tag);
    endtask

    task automatic drive_cfg(input logic sel);
        cfg_rp_mask   = sel ? 8'h00 : 8'h05;
        cfg_addr_base = 48'h10000;
        cfg_addr_mask = 48'hFFF00;
        cfg_addr_en   = sel;
    endtask

    task automatic load_cfg(input logic sel);
        @(negedge clk);
        count_en = 1'b0; cfg_wr = 1'b1; drive_cfg(sel);
        @(negedge clk);
        cfg_wr = 1'b0; count_en = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_all("R1 reset");
        check(cnt_cycles == 0, "R1 reset cycles", cnt_cycles, 0);
        repeat (3) @(negedge clk);
        check(cnt_cycles == 0, "R2 hold while disabled", cnt_cycles, 0);

        // R1 default filter: BAR to port 7 counted, CXL not (R6)
        count_en = 1'b1;
        send(1'b0, 1'b0, 3'd7, 8'd10, 48'h123, 1'b1, 1'b1, "R1 default port 7");
        send(1'b1, 1'b0, 3'd7, 8'd10, 48'h0,   1'b1, 1'b0, "R6 default CXL");

        // R2 cycle step
        cyc0 = cnt_cycles;
        repeat (5) @(negedge clk);
        check(cnt_cycles == cyc0 + 5, "R2 cycle step", cnt_cycles, cyc0 + 5);

        // R3 gating by count_en and req_valid
        @(negedge clk); count_en = 1'b0;
        send(1'b0, 1'b0, 3'd0, 8'd9, 48'h0, 1'b1, 1'b0, "R3 count_en low");
        cyc0 = cnt_cycles;
        @(negedge clk);
        check(cnt_cycles == cyc0, "R2 hold after disable", cnt_cycles, cyc0);
        count_en = 1'b1;
        send(1'b0, 1'b1, 3'd0, 8'd9, 48'h0, 1'b0, 1'b0, "R3 valid low");

        // table walk: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            if (i == 0 || VEC[i].sel != VEC[i-1].sel) load_cfg(VEC[i].sel);
            send(VEC[i].cxl, VEC[i].wr, VEC[i].rp, VEC[i].bytes, VEC[i].addr,
                 1'b1, VEC[i].hit, $sformatf("R4/R5/R6/R7/R9 vec %0d", i));
        end

        // R8 write while counting is ignored: window filter stays active
        @(negedge clk);
        cfg_wr = 1'b1; drive_cfg(1'b0);
        @(negedge clk);
        cfg_wr = 1'b0;
        send(1'b1, 1'b0, 3'd1, 8'd3, 48'h10010, 1'b1, 1'b1, "R8 ignored write");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule